// File: doc/BRIEF.md
# Processor Interrupt Level Selector

This block sits in front of a processor's trap logic and turns a set of prioritised interrupt level lines into one external-interrupt trap request. It keeps a registered bitmap of every line that is currently asserted. It picks the highest active level and presents a trap index built from a fixed external-interrupt base code combined with that level.

The index is re-arbitrated whenever the bitmap changes and again on the edge where the processor reports that it took the trap. As a result, a level that is still active, or a lower one that is waiting, is presented again straight away. While the processor signals that a different, non-external trap is pending, the block leaves the presented index alone. When every line has dropped, it withdraws the request. A separate one-cycle wake pulse tells the processor to leave a halted state whenever a line newly asserts.

Top module: `pil_select`

## Requirements
- R1: Bit k of `lvl_in` carries interrupt level k+1, so bit 0 is level 1 and bit 14 is level 15. The lines are captured into the bitmap on every clock edge. A change on the lines shows up on `trap_idx` after the second rising edge following the change.
- R2: Among the set bits of the bitmap, the highest level wins. Level 0 is never produced.
- R3: A presented index equals `EXT_BASE` (default 0x10, low 4 bits zero) ORed with the winning level in the low 4 bits. An index of 0 means that nothing is presented.
- R4: `irq_req` is high exactly when a nonzero index is presented. A new index is loaded only when it differs from the current one.
- R5: While `other_pend` is high and `trap_taken` is low, `trap_idx` and `irq_req` hold their values whatever the lines do.
- R6: When the bitmap is empty and `other_pend` is low, the index is cleared to 0 and `irq_req` goes low.
- R7: On an edge with `trap_taken` high, the index is cleared and re-evaluated in the same edge. If lines are still set and `other_pend` is low, the highest of them is presented at once. If `other_pend` is high, the index is left at 0.
- R8: `wake` pulses high for one cycle after the edge that captures a newly asserted line. Dropping a line gives no pulse.
- R9: A synchronous active-high `rst` clears the bitmap, the index, `irq_req` and `wake`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_in | input | 15 | Interrupt level lines, bit k = level k+1 |
| other_pend | input | 1 | A non-external trap is pending in the processor |
| trap_taken | input | 1 | One-cycle pulse: processor entered the presented trap |
| irq_req | output | 1 | External-interrupt trap request |
| trap_idx | output | 8 | Presented trap index (base OR level), 0 when idle |
| wake | output | 1 | One-cycle pulse to leave the halted state |

## Verification
The bench targets re-arbitration on both rising and falling lines. A design that latched only the first raised level would keep level 15 after that line dropped, instead of falling back to level 4. It checks that a taken trap re-presents a still-active line on the same edge; a design that only cleared the index would show 0 there. It also checks that `other_pend` freezes the index even when every line drops, and that it leaves the index at zero when it coincides with a taken trap. A design that let the pending trap be overridden would jump to a new level or clear early. The wake pulse is checked for one-cycle width and for staying silent when a line falls.

// File: rtl/pil_select_pkg.sv
package pil_select_pkg;

    typedef enum logic [1:0] {
        DEC_KEEP  = 2'd0,
        DEC_POST  = 2'd1,
        DEC_CLEAR = 2'd2,
        DEC_BLOCK = 2'd3
    } pil_dec_e;

    typedef struct packed {
        logic       any;
        logic [3:0] level;
    } pil_win_t;

    function automatic logic [7:0] make_code(input logic [7:0] base, input logic [3:0] level);
        return base | {4'b0000, level};
    endfunction

endpackage

// File: rtl/pil_bitmap.sv
module pil_bitmap #(
    parameter int LEVELS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] lvl_in,
    output logic [LEVELS-1:0] pil_q,
    output logic              wake_q
);
    logic [LEVELS-1:0] rising;

    assign rising = lvl_in & ~pil_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pil_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            pil_q  <= lvl_in;
            wake_q <= |rising;
        end
    end

    // R8: a wake pulse always comes with a bit that is now set in the bitmap
    p_wake_has_line_r8: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> (|pil_q));

endmodule

// File: rtl/pil_prio.sv
module pil_prio
    import pil_select_pkg::*;
#(
    parameter int LEVELS = 15,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] pil,
    output pil_win_t          win
);
    logic [LEVELS-1:0] grant;
    logic [LVL_W-1:0]  top;

    for (genvar g = 0; g < LEVELS; g++) begin : g_grant
        if (g == LEVELS - 1) begin : g_top
            assign grant[g] = pil[g];
        end else begin : g_rest
            assign grant[g] = pil[g] & ~(|pil[LEVELS-1:g+1]);
        end
    end

    always_comb begin
        top = '0;
        for (int k = 0; k < LEVELS; k++) begin
            if (grant[k]) top = top | LVL_W'(k + 1);
        end
    end

    always_comb begin
        win       = '0;
        win.any   = |grant;
        win.level = 4'(top);
    end

    // R2: exactly one winner at most, and a winner whenever any bit is set
    p_one_winner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((|pil) == (|grant)));

endmodule

// File: rtl/pil_trap_ctrl.sv
module pil_trap_ctrl
    import pil_select_pkg::*;
#(
    parameter int               IDX_W    = 8,
    parameter logic [IDX_W-1:0] EXT_BASE = 'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  pil_win_t         win,
    input  logic             other_pend,
    input  logic             trap_taken,
    output logic [IDX_W-1:0] idx_q,
    output logic             req_q
);
    localparam int LVL_W = 4;

    logic [IDX_W-1:0] cur_eff;
    logic [IDX_W-1:0] cand;
    logic [IDX_W-1:0] idx_d;
    logic             req_d;
    pil_dec_e         dec;

    assign cur_eff = trap_taken ? '0 : idx_q;
    assign cand    = IDX_W'(make_code(8'(EXT_BASE), win.level));

    always_comb begin
        if (other_pend)            dec = DEC_BLOCK;
        else if (!win.any)         dec = DEC_CLEAR;
        else if (cand != cur_eff)  dec = DEC_POST;
        else                       dec = DEC_KEEP;
    end

    always_comb begin
        idx_d = cur_eff;
        req_d = req_q;
        unique case (dec)
            DEC_POST:  begin idx_d = cand; req_d = 1'b1; end
            DEC_CLEAR: begin idx_d = '0;   req_d = 1'b0; end
            DEC_BLOCK: begin idx_d = cur_eff; req_d = trap_taken ? 1'b0 : req_q; end
            default:   begin idx_d = cur_eff; req_d = req_q; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            req_q <= 1'b0;
        end else begin
            idx_q <= idx_d;
            req_q <= req_d;
        end
    end

    // R3: a presented code carries the base above a nonzero level
    p_code_form_r3: assert property (@(posedge clk) disable iff (rst)
        (idx_q != '0) |-> ((idx_q[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W]) && (idx_q[LVL_W-1:0] != '0)));

    // R4: request and presented index agree
    p_req_matches_r4: assert property (@(posedge clk) disable iff (rst)
        req_q == (idx_q != '0));

    // R5: a pending non-external trap freezes the index
    p_hold_other_r5: assert property (@(posedge clk) disable iff (rst)
        (other_pend && !trap_taken) |=> $stable(idx_q));

    // R6: empty bitmap withdraws the request
    p_clear_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (!other_pend && !trap_taken && !win.any) |=> (idx_q == '0) && !req_q);

    // R7: taken trap with another trap pending leaves nothing presented
    p_taken_blocked_r7: assert property (@(posedge clk) disable iff (rst)
        (trap_taken && other_pend) |=> (idx_q == '0));

endmodule

// File: rtl/pil_select.sv
module pil_select
    import pil_select_pkg::*;
#(
    parameter int         LEVELS   = 15,
    parameter int         IDX_W    = 8,
    parameter logic [7:0] EXT_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] lvl_in,
    input  logic              other_pend,
    input  logic              trap_taken,
    output logic              irq_req,
    output logic [IDX_W-1:0]  trap_idx,
    output logic              wake
);
    localparam int LVL_W = $clog2(LEVELS + 1);

    logic [LEVELS-1:0] pil_q;
    pil_win_t          win;

    pil_bitmap #(.LEVELS(LEVELS)) u_bitmap (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (lvl_in),
        .pil_q  (pil_q),
        .wake_q (wake)
    );

    pil_prio #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_prio (
        .clk (clk),
        .rst (rst),
        .pil (pil_q),
        .win (win)
    );

    pil_trap_ctrl #(.IDX_W(IDX_W), .EXT_BASE(IDX_W'(EXT_BASE))) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .win        (win),
        .other_pend (other_pend),
        .trap_taken (trap_taken),
        .idx_q      (trap_idx),
        .req_q      (irq_req)
    );

    // R9: reset leaves the outputs idle on the following cycle
    p_reset_idle_r9: assert property (@(posedge clk)
        $past(rst) |-> (!irq_req && (trap_idx == '0) && !wake));

endmodule

// File: tb/pil_select_bench.sv
module pil_select_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] lvl_in = '0;
    logic        other_pend = 1'b0;
    logic        trap_taken = 1'b0;
    logic        irq_req;
    logic [7:0]  trap_idx;
    logic        wake;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pil_select u_pil_select (
        .clk        (clk),
        .rst        (rst),
        .lvl_in     (lvl_in),
        .other_pend (other_pend),
        .trap_taken (trap_taken),
        .irq_req    (irq_req),
        .trap_idx   (trap_idx),
        .wake       (wake)
    );

    // {lines, other_pend, expected index}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {15'h0000, 1'b0, 8'h00},  // R6 idle
        {15'h0001, 1'b0, 8'h11},  // R1 R3 level 1
        {15'h0009, 1'b0, 8'h14},  // R2 levels 1,4
        {15'h4009, 1'b0, 8'h1F},  // R2 level 15 joins
        {15'h0009, 1'b0, 8'h14},  // R2 fall back after drop
        {15'h7FFF, 1'b0, 8'h1F},  // R2 all lines
        {15'h0000, 1'b0, 8'h00},  // R6 all dropped
        {15'h0800, 1'b0, 8'h1C},  // R3 level 12
        {15'h4800, 1'b1, 8'h1C},  // R5 higher line blocked
        {15'h0000, 1'b1, 8'h1C},  // R5 empty but held
        {15'h0000, 1'b0, 8'h00},  // R6 released and cleared
        {15'h0004, 1'b0, 8'h13}   // R1 level 3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset idx", 32'(trap_idx), 32'h0);
        check("R9 reset req", 32'(irq_req), 32'h0);
        check("R9 reset wake", 32'(wake), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            lvl_in     = VEC[i][23:9];
            other_pend = VEC[i][8];
            @(posedge clk);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2 R3 vec%0d idx", i), 32'(trap_idx), 32'(VEC[i][7:0]));
            check($sformatf("R4 vec%0d req", i), 32'(irq_req), 32'(VEC[i][7:0] != 8'h00));
        end

        // R1: one edge after a change the index has not moved yet
        lvl_in = 15'h0040;
        @(posedge clk);
        @(negedge clk);
        check("R1 latency first edge", 32'(trap_idx), 32'h13);
        @(posedge clk);
        @(negedge clk);
        check("R1 latency second edge", 32'(trap_idx), 32'h17);

        // R7: taken trap with line still active re-presents it
        trap_taken = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trap_taken = 1'b0;
        check("R7 re-present idx", 32'(trap_idx), 32'h17);
        check("R7 re-present req", 32'(irq_req), 32'h1);

        // R7: taken with other trap pending leaves index clear
        trap_taken = 1'b1;
        other_pend = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trap_taken = 1'b0;
        check("R7 blocked idx", 32'(trap_idx), 32'h00);
        check("R7 blocked req", 32'(irq_req), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R5 stays clear", 32'(trap_idx), 32'h00);
        other_pend = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R7 reselect idx", 32'(trap_idx), 32'h17);

        // R8: wake pulse on a new line, one cycle wide
        lvl_in = 15'h0042;
        @(posedge clk);
        @(negedge clk);
        check("R8 wake high", 32'(wake), 32'h1);
        @(posedge clk);
        @(negedge clk);
        check("R8 wake one cycle", 32'(wake), 32'h0);
        check("R2 level 7 over 2", 32'(trap_idx), 32'h17);
        lvl_in = 15'h0040;
        @(posedge clk);
        @(negedge clk);
        check("R8 no wake on drop", 32'(wake), 32'h0);

        // R9: reset during activity
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid reset idx", 32'(trap_idx), 32'h00);
        check("R9 mid reset req", 32'(irq_req), 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset idx", 32'(trap_idx), 32'h17);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule